// File: doc/BRIEF.md
# Posted Write Buffer, PCI Target to Local Bus

This block sits behind the target side of a PCI interface and absorbs write transactions that have already been decoded as hitting the device. Each address phase and each completed data phase becomes one entry in a small queue. The PCI side therefore finishes without waiting for the local module. When the queue is full, the block holds off the initiator with a stop/retry indication and accepts the remaining data once room returns.

On the local side, a drain engine empties the queue as 486-style write cycles. It raises a hold request and waits for the module's hold acknowledge. It then takes the address entry of a burst and presents each following data entry as one beat, with an address strobe on the first beat, a burst-last strobe on the final beat and an address that advances by one word per beat. It retires a beat when the module returns ready, and drops the hold request once the queue is empty and the final beat has been acknowledged. A mode input shrinks the queue to a single holding stage.

Top module: `pci_post_wbuf`

## Requirements
- R1: Each queue entry carries a 32-bit address or data word and a 4-bit command/byte-enable field. The local side delivers every data word and its byte enables in the order the PCI side accepted them. The queue never holds more than DEPTH (default 4) entries.
- R2: An address phase (`pci_frame_n` low with `pci_hit` high) that finds room is claimed: `pci_devsel_n` goes low in the next cycle, and `pci_trdy_n` is low in every data phase while the queue has room. `pci_trdy_n` is never low without `pci_devsel_n` low.
- R3: While a claimed transaction finds the queue full, `pci_stop_n` and `pci_stop_oe_n` are both low and `pci_trdy_n` is high. `pci_stop_n` and `pci_stop_oe_n` are always equal, and stop is never low together with target ready.
- R4: Once an entry drains from a full queue, target ready returns and the stalled burst continues with no beat lost or repeated.
- R5: An address phase that finds the queue full is not claimed. `pci_devsel_n` stays high and `pci_stop_n` is low until the initiator's final phase (`pci_irdy_n` low with `pci_frame_n` high), and nothing is queued.
- R6: `loc_hold` goes high while entries are waiting, and no address strobe is issued before `loc_hlda` has been seen high.
- R7: `loc_ads_n` is low for exactly one cycle, at the first beat of each burst. `loc_wr` is high during every beat. `loc_addr` equals the burst address plus 4 times the beat index. `loc_mem` equals bit 2 of the command code (memory write 0111 gives 1, I/O write 0011 gives 0).
- R8: `loc_blast_n` is low during the last beat of a burst, the one taken in the PCI phase with `pci_frame_n` high, and high during every other beat.
- R9: A beat's address, data and byte enables stay stable until `loc_rdy_n` is sampled low. One entry is retired per acknowledged beat.
- R10: `loc_hold` falls in the cycle after the acknowledge of a burst's final beat when the queue is then empty.
- R11: With `post_en` low, the queue accepts only one entry at a time. A burst stalls with stop after its address phase until that entry drains, and its data still arrives in order.
- R12: A synchronous high `rst` empties the queue and returns all strobes inactive (`pci_devsel_n`, `pci_trdy_n`, `pci_stop_n`, `pci_stop_oe_n`, `loc_ads_n` and `loc_blast_n` high; `loc_hold` and `loc_wr` low). Entries queued before the reset are never replayed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for PCI and local sides |
| rst | input | 1 | Synchronous reset, active high |
| post_en | input | 1 | 1: full-depth queue; 0: single holding stage |
| pci_hit | input | 1 | Address decode hit, valid in the address phase |
| pci_frame_n | input | 1 | PCI frame, active low |
| pci_irdy_n | input | 1 | PCI initiator ready, active low |
| pci_ad | input | 32 | PCI address/data |
| pci_cbe_n | input | 4 | PCI command / byte enables, active low |
| pci_devsel_n | output | 1 | Device select, active low |
| pci_trdy_n | output | 1 | Target ready, active low |
| pci_stop_n | output | 1 | Stop/retry request, active low |
| pci_stop_oe_n | output | 1 | Output enable for the stop line, active low |
| loc_hlda | input | 1 | Local hold acknowledge, active high |
| loc_rdy_n | input | 1 | Local ready, beat taken, active low |
| loc_hold | output | 1 | Local bus hold request, active high |
| loc_ads_n | output | 1 | Local address strobe, active low |
| loc_blast_n | output | 1 | Local burst-last, active low |
| loc_wr | output | 1 | Write/read indicator, high for write beats |
| loc_mem | output | 1 | Memory (1) or I/O (0) cycle |
| loc_addr | output | 32 | Local beat address |
| loc_data | output | 32 | Local write data |
| loc_be_n | output | 4 | Local byte enables, active low |

## Verification
The bench fills the queue with the hold acknowledge withheld, so that a burst stalls mid-stream and an address phase meets a full queue. A design that overran the queue, dropped or repeated the stalled beat, or claimed the rejected transaction would show a wrong beat count or a wrong data order. Bursts of one to six beats are replayed with and without local wait states. These catch an address strobe repeated on later beats, burst-last on the wrong beat, an address that fails to advance, a beat retired without ready, and a hold request that lingers. Single-stage mode checks that stop appears right after the address phase, and a reset taken with entries queued must leave nothing to replay.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int AD_W = 32;
  localparam int BE_W = 4;

  // One queued PCI phase plus two markers written by the intake side
  typedef struct packed {
    logic            head;   // address phase of a burst
    logic            tail;   // final data phase of a burst
    logic [BE_W-1:0] cbe_n;  // command (head) or byte enables (data)
    logic [AD_W-1:0] ad;     // address (head) or data
  } pwb_entry_t;

  localparam int ENTRY_W = $bits(pwb_entry_t);

  typedef enum logic [1:0] {IN_IDLE, IN_DATA, IN_REJ} in_state_t;
  typedef enum logic [1:0] {DR_IDLE, DR_HOLD, DR_WAIT, DR_BEAT} dr_state_t;
endpackage

// File: rtl/pwb_store.sv
module pwb_store #(
  parameter int DEPTH = 4,
  parameter int W     = 38,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] level,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  // storage array without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];
  assign empty = (level == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/pwb_intake.sv
module pwb_intake
  import pwb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            post_en,
  input  logic            hit,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] cbe_n,
  input  logic [CW-1:0]   level,
  output logic            push,
  output pwb_entry_t      entry,
  output logic            devsel_n,
  output logic            trdy_n,
  output logic            stop_n,
  output logic            stop_oe_n
);
  localparam logic [CW-1:0] CAP_FULL = CW'(DEPTH);

  in_state_t st;
  logic      full;

  // single-stage mode: one entry already counts as full
  assign full = post_en ? (level >= CAP_FULL) : (level != '0);

  always_comb begin
    push  = 1'b0;
    entry = '0;
    unique case (st)
      IN_IDLE: begin
        if (!frame_n && hit && !full) begin
          push        = 1'b1;
          entry.head  = 1'b1;
          entry.tail  = 1'b0;
          entry.cbe_n = cbe_n;
          entry.ad    = ad;
        end
      end
      IN_DATA: begin
        if (!irdy_n && !full) begin
          push        = 1'b1;
          entry.head  = 1'b0;
          entry.tail  = frame_n;
          entry.cbe_n = cbe_n;
          entry.ad    = ad;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= IN_IDLE;
    end else begin
      unique case (st)
        IN_IDLE: if (!frame_n && hit) st <= full ? IN_REJ : IN_DATA;
        IN_DATA: if (!irdy_n && !full && frame_n) st <= IN_IDLE;
        IN_REJ:  if (!irdy_n && frame_n) st <= IN_IDLE;
        default: st <= IN_IDLE;
      endcase
    end
  end

  // strobes decoded only from flops (state and queue level)
  assign devsel_n  = !(st == IN_DATA);
  assign trdy_n    = !(st == IN_DATA && !full);
  assign stop_n    = !((st == IN_DATA && full) || st == IN_REJ);
  assign stop_oe_n = stop_n;
endmodule

// File: rtl/pwb_drain.sv
module pwb_drain
  import pwb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            empty,
  input  pwb_entry_t      head_e,
  output logic            pop,
  input  logic            hlda,
  input  logic            rdy_n,
  output logic            hold,
  output logic            ads_n,
  output logic            blast_n,
  output logic            wr,
  output logic            mem,
  output logic [AD_W-1:0] addr,
  output logic [AD_W-1:0] data,
  output logic [BE_W-1:0] be_n
);
  localparam logic [AD_W-1:0] STEP = AD_W'(BE_W);

  dr_state_t st;
  logic      first_q;
  logic      take_addr, take_data;

  assign take_addr = (st == DR_HOLD) && hlda && !empty && head_e.head;
  assign take_data = (st == DR_WAIT) && !empty && !head_e.head;
  assign pop       = take_addr || take_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= DR_IDLE;
      hold    <= 1'b0;
      ads_n   <= 1'b1;
      blast_n <= 1'b1;
      wr      <= 1'b0;
      mem     <= 1'b0;
      first_q <= 1'b0;
      addr    <= '0;
      data    <= '0;
      be_n    <= '0;
    end else begin
      ads_n <= 1'b1;
      unique case (st)
        DR_IDLE: begin
          if (!empty) begin
            hold <= 1'b1;
            st   <= DR_HOLD;
          end
        end
        DR_HOLD: begin
          if (take_addr) begin
            addr    <= head_e.ad;
            mem     <= head_e.cbe_n[2];
            first_q <= 1'b1;
            st      <= DR_WAIT;
          end
        end
        DR_WAIT: begin
          if (take_data) begin
            data    <= head_e.ad;
            be_n    <= head_e.cbe_n;
            blast_n <= !head_e.tail;
            ads_n   <= !first_q;
            first_q <= 1'b0;
            wr      <= 1'b1;
            st      <= DR_BEAT;
          end
        end
        DR_BEAT: begin
          if (!rdy_n) begin
            wr      <= 1'b0;
            blast_n <= 1'b1;
            if (!blast_n) begin
              if (empty) begin
                hold <= 1'b0;
                st   <= DR_IDLE;
              end else begin
                st <= DR_HOLD;
              end
            end else begin
              addr <= addr + STEP;
              st   <= DR_WAIT;
            end
          end
        end
        default: st <= DR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_post_wbuf.sv
module pci_post_wbuf
  import pwb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            post_en,
  input  logic            pci_hit,
  input  logic            pci_frame_n,
  input  logic            pci_irdy_n,
  input  logic [31:0]     pci_ad,
  input  logic [3:0]      pci_cbe_n,
  output logic            pci_devsel_n,
  output logic            pci_trdy_n,
  output logic            pci_stop_n,
  output logic            pci_stop_oe_n,
  input  logic            loc_hlda,
  input  logic            loc_rdy_n,
  output logic            loc_hold,
  output logic            loc_ads_n,
  output logic            loc_blast_n,
  output logic            loc_wr,
  output logic            loc_mem,
  output logic [31:0]     loc_addr,
  output logic [31:0]     loc_data,
  output logic [3:0]      loc_be_n
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          q_push, q_pop, q_empty;
  logic [CW-1:0] buf_level;
  pwb_entry_t    in_entry, out_entry;
  logic [ENTRY_W-1:0] out_raw;

  pwb_intake #(.DEPTH(DEPTH), .CW(CW)) u_intake (
    .clk      (clk),
    .rst      (rst),
    .post_en  (post_en),
    .hit      (pci_hit),
    .frame_n  (pci_frame_n),
    .irdy_n   (pci_irdy_n),
    .ad       (pci_ad),
    .cbe_n    (pci_cbe_n),
    .level    (buf_level),
    .push     (q_push),
    .entry    (in_entry),
    .devsel_n (pci_devsel_n),
    .trdy_n   (pci_trdy_n),
    .stop_n   (pci_stop_n),
    .stop_oe_n(pci_stop_oe_n)
  );

  pwb_store #(.DEPTH(DEPTH), .W(ENTRY_W), .CW(CW)) u_store (
    .clk  (clk),
    .rst  (rst),
    .push (q_push),
    .wdata(in_entry),
    .pop  (q_pop),
    .rdata(out_raw),
    .level(buf_level),
    .empty(q_empty)
  );

  assign out_entry = pwb_entry_t'(out_raw);

  pwb_drain u_drain (
    .clk    (clk),
    .rst    (rst),
    .empty  (q_empty),
    .head_e (out_entry),
    .pop    (q_pop),
    .hlda   (loc_hlda),
    .rdy_n  (loc_rdy_n),
    .hold   (loc_hold),
    .ads_n  (loc_ads_n),
    .blast_n(loc_blast_n),
    .wr     (loc_wr),
    .mem    (loc_mem),
    .addr   (loc_addr),
    .data   (loc_data),
    .be_n   (loc_be_n)
  );
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          devsel_n,
  input logic          trdy_n,
  input logic          stop_n,
  input logic          stop_oe_n,
  input logic          hold,
  input logic          ads_n,
  input logic          blast_n,
  input logic          wr,
  input logic          rdy_n,
  input logic [31:0]   addr,
  input logic [31:0]   data,
  input logic [3:0]    be_n,
  input logic [CW-1:0] level
);
  localparam logic [CW-1:0] LEVEL_MAX = CW'(DEPTH);

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LEVEL_MAX);

  // R2
  trdy_claimed_chk: assert property (@(posedge clk) disable iff (rst)
    !trdy_n |-> !devsel_n);

  // R3
  stop_oe_pair_chk: assert property (@(posedge clk) disable iff (rst)
    stop_n == stop_oe_n);

  // R3
  trdy_stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!trdy_n && !stop_n));

  // R6
  ads_under_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ads_n |-> hold);

  // R7
  ads_single_chk: assert property (@(posedge clk) disable iff (rst)
    !ads_n |=> ads_n);

  // R8
  blast_in_beat_chk: assert property (@(posedge clk) disable iff (rst)
    !blast_n |-> wr);

  // R9
  beat_held_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && rdy_n) |=> (wr && $stable(data) && $stable(be_n) && $stable(addr)));
endmodule

bind pci_post_wbuf pwb_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .devsel_n (pci_devsel_n),
  .trdy_n   (pci_trdy_n),
  .stop_n   (pci_stop_n),
  .stop_oe_n(pci_stop_oe_n),
  .hold     (loc_hold),
  .ads_n    (loc_ads_n),
  .blast_n  (loc_blast_n),
  .wr       (loc_wr),
  .rdy_n    (loc_rdy_n),
  .addr     (loc_addr),
  .data     (loc_data),
  .be_n     (loc_be_n),
  .level    (buf_level)
);

// File: tb/pci_post_wbuf_tb.sv
`timescale 1ns/1ps
module pci_post_wbuf_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        post_en = 1'b1;
  logic        pci_hit = 1'b0, pci_frame_n = 1'b1, pci_irdy_n = 1'b1;
  logic [31:0] pci_ad = '0;
  logic [3:0]  pci_cbe_n = '1;
  logic        pci_devsel_n, pci_trdy_n, pci_stop_n, pci_stop_oe_n;
  logic        loc_hlda = 1'b0, loc_rdy_n = 1'b1;
  logic        loc_hold, loc_ads_n, loc_blast_n, loc_wr, loc_mem;
  logic [31:0] loc_addr, loc_data;
  logic [3:0]  loc_be_n;

  always #4 clk = ~clk;

  pci_post_wbuf u_dut (.*);

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // local responder settings and beat log
  bit          hlda_en = 1'b1, ws_en = 1'b0, ads_early = 1'b0;
  int          r_n = 0;
  logic [31:0] r_addr [128];
  logic [31:0] r_data [128];
  logic [3:0]  r_be   [128];
  bit          r_last [128];
  bit          r_ads  [128];
  bit          r_mem  [128];

  // vector: ws[48] beats[47:44] cmd[43:40] addr[39:8] seed[7:0]
  localparam logic [48:0] VECS [6] = '{
    {1'b0, 4'd1, 4'b0111, 32'h1000_0000, 8'h11},
    {1'b0, 4'd3, 4'b0111, 32'h2000_0040, 8'h5a},
    {1'b1, 4'd2, 4'b0011, 32'h0000_0cf8, 8'h33},
    {1'b1, 4'd6, 4'b1111, 32'h8000_1000, 8'hc4},
    {1'b0, 4'd5, 4'b0011, 32'h0000_0400, 8'h7e},
    {1'b1, 4'd4, 4'b0111, 32'hfff0_0010, 8'h99}
  };

  function automatic logic [31:0] beat_data(input logic [7:0] s, input int i);
    return {s, 8'(i), ~s, s ^ 8'(i * 37)};
  endfunction

  function automatic logic [3:0] beat_be(input int i);
    return 4'((i * 3) ^ 6);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // local module model: hold acknowledge and ready with optional wait states
  initial begin
    bit ws = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        loc_hlda  = 1'b0;
        loc_rdy_n = 1'b1;
        ws = 0;
      end else begin
        if (!loc_ads_n && !loc_hlda) ads_early = 1'b1;
        if (!loc_ads_n && r_n < 128) r_ads[r_n] = 1'b1;
        loc_hlda  = loc_hold && hlda_en;
        loc_rdy_n = 1'b1;
        if (loc_wr && r_n < 128) begin
          if (!ws_en || ws) begin
            r_addr[r_n] = loc_addr;
            r_data[r_n] = loc_data;
            r_be[r_n]   = loc_be_n;
            r_last[r_n] = !loc_blast_n;
            r_mem[r_n]  = loc_mem;
            r_n++;
            if (r_n < 128) r_ads[r_n] = 1'b0;
            loc_rdy_n = 1'b0;
            ws = 0;
          end else begin
            ws = 1;
          end
        end
      end
    end
  end

  // PCI initiator: one write burst of n data phases
  task automatic pci_write(input logic [31:0] a, input logic [3:0] cmd, input int n,
                           input logic [7:0] s, output bit claimed,
                           output int stalls, output bit rej_stop);
    stalls = 0;
    rej_stop = 0;
    @(negedge clk);
    pci_hit = 1'b1; pci_frame_n = 1'b0; pci_ad = a; pci_cbe_n = cmd; pci_irdy_n = 1'b1;
    @(negedge clk);
    pci_hit = 1'b0;
    claimed = !pci_devsel_n;
    if (!claimed) begin
      rej_stop = !pci_stop_n && !pci_stop_oe_n && pci_trdy_n;
      pci_frame_n = 1'b1; pci_irdy_n = 1'b0;
      @(negedge clk);
      pci_irdy_n = 1'b1;
      return;
    end
    for (int i = 0; i < n; i++) begin
      pci_ad = beat_data(s, i);
      pci_cbe_n = beat_be(i);
      pci_irdy_n = 1'b0;
      pci_frame_n = (i == n - 1);
      while (pci_trdy_n) begin
        if (!pci_stop_n && !pci_stop_oe_n) stalls++;
        @(negedge clk);
      end
      @(negedge clk);
    end
    pci_irdy_n = 1'b1; pci_frame_n = 1'b1; pci_ad = '0; pci_cbe_n = '1;
  endtask

  task automatic check_burst(input int b, input logic [31:0] a, input logic [3:0] cmd,
                             input int n, input logic [7:0] s, input string req);
    for (int i = 0; i < n; i++) begin
      chk(r_data[b+i] == beat_data(s, i), req, "R1 beat data", r_data[b+i], beat_data(s, i));
      chk(r_be[b+i] == beat_be(i), req, "R1 beat byte enables", 32'(r_be[b+i]), 32'(beat_be(i)));
      chk(r_addr[b+i] == a + 32'(4 * i), req, "R7 beat address", r_addr[b+i], a + 32'(4 * i));
      chk(r_ads[b+i] == (i == 0), req, "R7 address strobe on first beat only",
          32'(r_ads[b+i]), 32'(i == 0));
      chk(r_mem[b+i] == cmd[2], req, "R7 memory/io from command bit 2",
          32'(r_mem[b+i]), 32'(cmd[2]));
      chk(r_last[b+i] == (i == n - 1), req, "R8 burst-last on final beat",
          32'(r_last[b+i]), 32'(i == n - 1));
    end
  endtask

  task automatic wait_drain(input int target);
    wait (r_n >= target);
    @(negedge clk);
    chk(loc_hold == 1'b0, "R10", "hold dropped after final acknowledge", 32'(loc_hold), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog run did not complete actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    bit cl, rs;
    int st, b;
    logic [48:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(loc_hold == 0 && loc_wr == 0, "R12", "hold/wr idle", {loc_hold, loc_wr}, 0);
    chk(loc_ads_n && loc_blast_n, "R12", "local strobes idle", {loc_ads_n, loc_blast_n}, 3);
    chk(pci_devsel_n && pci_trdy_n, "R12", "devsel/trdy idle", {pci_devsel_n, pci_trdy_n}, 3);
    chk(pci_stop_n && pci_stop_oe_n, "R12", "stop/oe idle", {pci_stop_n, pci_stop_oe_n}, 3);

    // table walk: R1 R2 R7 R8 R9 R10
    for (int k = 0; k < 6; k++) begin
      v = VECS[k];
      ws_en = v[48];
      b = r_n;
      pci_write(v[39:8], v[43:40], int'(v[47:44]), v[7:0], cl, st, rs);
      chk(cl, "R2", "burst claimed", 32'(cl), 1);
      wait_drain(b + int'(v[47:44]));
      chk(r_n == b + int'(v[47:44]), "R9", "one beat per data phase", r_n - b, 32'(v[47:44]));
      check_burst(b, v[39:8], v[43:40], int'(v[47:44]), v[7:0], "R9");
    end
    ws_en = 1'b0;

    // R3 / R4: stall mid-burst with the local side held off
    hlda_en = 1'b0;
    b = r_n;
    fork
      pci_write(32'h4000_0000, 4'b0111, 5, 8'h3c, cl, st, rs);
      begin
        repeat (12) @(negedge clk);
        chk(!pci_stop_n && !pci_stop_oe_n, "R3", "stop and its enable low when full",
            {pci_stop_n, pci_stop_oe_n}, 0);
        chk(pci_trdy_n && !pci_devsel_n, "R3", "trdy high, devsel held",
            {pci_trdy_n, pci_devsel_n}, 2);
        chk(loc_hold == 1'b1, "R6", "hold raised while entries wait", 32'(loc_hold), 1);
        chk(r_n == b, "R6", "no beat before acknowledge", r_n - b, 0);
        hlda_en = 1'b1;
      end
    join
    chk(st > 0, "R3", "stall observed", st, 1);
    wait_drain(b + 5);
    check_burst(b, 32'h4000_0000, 4'b0111, 5, 8'h3c, "R4");

    // R5: address phase against a full queue
    hlda_en = 1'b0;
    b = r_n;
    pci_write(32'h5000_0000, 4'b0111, 3, 8'ha5, cl, st, rs);
    pci_write(32'h6000_0000, 4'b0011, 2, 8'h0f, cl, st, rs);
    chk(!cl, "R5", "full queue leaves address phase unclaimed", 32'(cl), 0);
    chk(rs, "R5", "retry stop on rejected address phase", 32'(rs), 1);
    @(negedge clk);
    chk(pci_stop_n && pci_devsel_n, "R5", "stop released after final phase",
        {pci_stop_n, pci_devsel_n}, 3);
    hlda_en = 1'b1;
    wait_drain(b + 3);
    chk(r_n == b + 3, "R5", "rejected burst queued nothing", r_n - b, 3);
    check_burst(b, 32'h5000_0000, 4'b0111, 3, 8'ha5, "R5");
    b = r_n;
    pci_write(32'h6000_0000, 4'b0011, 2, 8'h0f, cl, st, rs);
    chk(cl, "R5", "retry claimed after drain", 32'(cl), 1);
    wait_drain(b + 2);
    check_burst(b, 32'h6000_0000, 4'b0011, 2, 8'h0f, "R5");

    // R11: single holding stage
    post_en = 1'b0;
    hlda_en = 1'b0;
    b = r_n;
    fork
      pci_write(32'h7000_0100, 4'b0111, 3, 8'he1, cl, st, rs);
      begin
        repeat (6) @(negedge clk);
        chk(!pci_stop_n && !pci_devsel_n, "R11", "stop after address in single-stage mode",
            {pci_stop_n, pci_devsel_n}, 0);
        hlda_en = 1'b1;
      end
    join
    wait_drain(b + 3);
    check_burst(b, 32'h7000_0100, 4'b0111, 3, 8'he1, "R11");
    post_en = 1'b1;

    // R12: reset with entries queued
    hlda_en = 1'b0;
    b = r_n;
    pci_write(32'h9000_0000, 4'b0111, 2, 8'h42, cl, st, rs);
    @(negedge clk);
    chk(loc_hold == 1'b1, "R6", "hold raised with queued burst", 32'(loc_hold), 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    hlda_en = 1'b1;
    repeat (10) @(negedge clk);
    chk(loc_hold == 1'b0, "R12", "hold low after reset", 32'(loc_hold), 0);
    chk(r_n == b, "R12", "no replay after reset", r_n - b, 0);
    chk(!ads_early, "R6", "no address strobe before acknowledge", 32'(ads_early), 0);

    finish_run();
  end
endmodule